// File: doc/BRIEF.md
# Supply Rail Control and Fault Status Register Bank

This block sits between a simple register write port and the analog side of a multi-rail supply controller. Software writes three control bytes: rail enables, rail voltage selects, and detector thresholds with a status-pin mode. The block turns them into per-rail enable and voltage-select outputs. Writes to the voltage selects are staged, so a running rail never sees its voltage change.

Seven digitised comparator results enter the block asynchronously: under-voltage, over-voltage, over-voltage protection, ACC input low, thermal warning, thermal shutdown and over-current. Each one is resynchronised. The block folds them into a live fault byte, which is returned with the stored voltage selects in one 16-bit readback word. It also drives two active-low status pins. Over-voltage protection and thermal shutdown override software and force the switchable rails off. The always-on logic supply rail is not controlled here.

Top module: `rail_ctrl_bank`

## Requirements
- R1: While `rstN` is low, every control register returns to 00h and every synchroniser stage returns to 0. After release with idle detectors, `railEn` is 0, every select output is 0, `rdWord` is 0000h and both status pins are high.
- R2: A write with `wrAddr`=0 loads `wrData[7:3]` into the enable register in the order ILM, CD, AUDIO, SYS, AMP. These map to `railEn[4:0]` and are visible after the write edge. `wrData[2:0]` is ignored, and writes with `wrAddr`=3 change nothing.
- R3: A write with `wrAddr`=1 stores the voltage selects: ILM in [7:6], CD in [5:4], AUDIO in [3:2] and SYS in bit 1. Bit 0 is ignored. `rdWord[15:9]` returns the stored bits 7..1 and `rdWord[8]` reads 0.
- R4: A rail's applied select output follows the stored select only while that rail's enable bit is 0. While the bit is 1, the applied select holds its last value. It catches up on the edge after the enable bit is cleared.
- R5: A write with `wrAddr`=2 drives `accThr` from [7:6], `uvThr` from [5:4] and `batMode` from bit 3. Bits [2:0] are not stored.
- R6: `rdWord[7:0]` is the live fault byte. Bit 7 is ACC low, 6 is UV, 5 is OV, 4 is OVP, 3 is thermal warning and 2 is over-current. Bits 1..0 read 0. Flags are not sticky, and a detector change appears after two clock edges.
- R7: While synchronised OVP is high, `railEn` is 0, the enable register is cleared, and enable writes are ignored. After OVP falls the rails stay off until software enables them again.
- R8: While synchronised thermal shutdown is high, `railEn` is 0 but the registers keep their contents. The rails come back after it falls.
- R9: `batFaultN` is low while UV, OV or OVP is present. It is also low on thermal warning when `batMode` is 1. When `batMode` is 0, thermal warning has no effect on the pin.
- R10: `accLowN` is low exactly while the synchronised ACC-low detector is high.
- R11: UV, OV, ACC low, thermal warning and over-current never change the enable register or `railEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low system reset, asynchronous assert |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select: 0 enables, 1 voltage selects, 2 thresholds/mode |
| wrData | input | 8 | Write data byte |
| detUv | input | 1 | Supply under-voltage comparator (async) |
| detOv | input | 1 | Supply over-voltage comparator (async) |
| detOvp | input | 1 | Over-voltage protection comparator (async) |
| detAccLow | input | 1 | ACC input low comparator (async) |
| detTwarn | input | 1 | Thermal warning comparator (async) |
| detTsd | input | 1 | Thermal shutdown comparator (async) |
| detOc | input | 1 | Any-rail over-current (async) |
| railEn | output | 5 | Rail enables {ILM, CD, AUDIO, SYS, AMP} |
| ilmSel | output | 2 | Applied ILM voltage select |
| cdSel | output | 2 | Applied CD voltage select |
| audSel | output | 2 | Applied AUDIO voltage select |
| sysSel | output | 1 | Applied SYS voltage select |
| accThr | output | 2 | ACC detector threshold select |
| uvThr | output | 2 | Under-voltage threshold select |
| batMode | output | 1 | Status pin mode: 1 adds thermal warning |
| rdWord | output | 16 | {stored voltage selects, 0, fault byte} |
| batFaultN | output | 1 | Active-low supply fault status pin |
| accLowN | output | 1 | Active-low ACC low status pin |

## Verification
The assertions assume that each detector input, once it changes, stays put for at least the two synchroniser edges before it changes again. The synchronised delay check depends on this. The stimulus meets it by driving every detector one time unit after a rising edge and holding each detector value for at least three cycles, including in the random phase. The write port is taken to be synchronous. The bench drives it on the same offset, so that a write, a protection event and a disable can land in the same cycle without a race.

// File: rtl/rail_bank_pkg.sv
package rail_bank_pkg;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 2;
  localparam int NUM_RAILS  = 5;
  localparam int NUM_DET    = 7;
  localparam int VSEL_W     = 7;
  localparam int DETCFG_W   = 5;
  localparam int RD_W       = 2 * DATA_W;

  localparam logic [ADDR_W-1:0] ADDR_EN   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_VSEL = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DET  = 2'd2;

  // detector vector positions; bits 5..0 form the fault byte bits 7..2
  localparam int DET_OC   = 0;
  localparam int DET_TW   = 1;
  localparam int DET_OVP  = 2;
  localparam int DET_OV   = 3;
  localparam int DET_UV   = 4;
  localparam int DET_ACC  = 5;
  localparam int DET_TSD  = 6;
  localparam int NUM_FLAG = 6;

  typedef struct packed {
    logic wrEnable;
    logic wrVsel;
    logic wrDet;
    logic ovpClr;
    logic railKill;
  } bankStrobe_t;
endpackage

// File: rtl/rail_bank_ctrl.sv
module rail_bank_ctrl
  import rail_bank_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [NUM_DET-1:0] detRaw,
  input  logic               batMode,
  output bankStrobe_t        strobe,
  output logic [NUM_DET-1:0] detSync,
  output logic               batFaultN,
  output logic               accLowN
);
  localparam int LAST = SYNC_STAGES - 1;

  genvar g;
  generate
    for (g = 0; g < NUM_DET; g++) begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[SYNC_STAGES-2:0], detRaw[g]};
      end
      assign detSync[g] = chain[LAST];
    end
  endgenerate

  logic ovpNow;
  logic supplyFault;
  assign ovpNow      = detSync[DET_OVP];
  assign supplyFault = detSync[DET_UV] | detSync[DET_OV] | ovpNow;

  always_comb begin
    strobe.wrEnable = wrEn && (wrAddr == ADDR_EN) && !ovpNow;
    strobe.wrVsel   = wrEn && (wrAddr == ADDR_VSEL);
    strobe.wrDet    = wrEn && (wrAddr == ADDR_DET);
    strobe.ovpClr   = ovpNow;
    strobe.railKill = ovpNow | detSync[DET_TSD];
  end

  assign batFaultN = !(supplyFault | (batMode & detSync[DET_TW]));
  assign accLowN   = !detSync[DET_ACC];

  AST_TWARN_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (detSync[DET_TW] && !batMode && !detSync[DET_UV] && !detSync[DET_OV] && !ovpNow) |-> batFaultN); // R9
  AST_UV_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(detSync[DET_UV]) |-> $past(detRaw[DET_UV], SYNC_STAGES)); // R6
  AST_NO_ENABLE_IN_OVP: assert property (@(posedge clk) disable iff (!rstN)
    ovpNow |-> !strobe.wrEnable); // R7
endmodule

// File: rtl/rail_bank_dp.sv
module rail_bank_dp
  import rail_bank_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  bankStrobe_t          strobe,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [NUM_FLAG-1:0]  flags,
  output logic [NUM_RAILS-1:0] railEn,
  output logic [1:0]           ilmSel,
  output logic [1:0]           cdSel,
  output logic [1:0]           audSel,
  output logic                 sysSel,
  output logic [1:0]           accThr,
  output logic [1:0]           uvThr,
  output logic                 batMode,
  output logic [RD_W-1:0]      rdWord
);
  localparam int PAD_W = DATA_W - NUM_FLAG;

  logic [NUM_RAILS-1:0] enReg;
  logic [VSEL_W-1:0]    vselReg, vselNext, applied;
  logic [DETCFG_W-1:0]  detReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 enReg <= '0;
    else if (strobe.ovpClr)    enReg <= '0;
    else if (strobe.wrEnable)  enReg <= wrData[DATA_W-1 -: NUM_RAILS];
  end

  assign vselNext = strobe.wrVsel ? wrData[DATA_W-1 -: VSEL_W] : vselReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vselReg <= '0;
      detReg  <= '0;
    end else begin
      vselReg <= vselNext;
      if (strobe.wrDet) detReg <= wrData[DATA_W-1 -: DETCFG_W];
    end
  end

  // each applied select bit belongs to rail (b+1)/2+1: SYS, AUDIO, CD, ILM
  genvar b;
  generate
    for (b = 0; b < VSEL_W; b++) begin : g_applied
      localparam int RAIL = (b + 1) / 2 + 1;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             applied[b] <= 1'b0;
        else if (!enReg[RAIL]) applied[b] <= vselNext[b];
      end
    end
  endgenerate

  assign railEn  = strobe.railKill ? '0 : enReg;
  assign ilmSel  = applied[6:5];
  assign cdSel   = applied[4:3];
  assign audSel  = applied[2:1];
  assign sysSel  = applied[0];
  assign accThr  = detReg[4:3];
  assign uvThr   = detReg[2:1];
  assign batMode = detReg[0];
  assign rdWord  = {vselReg, 1'b0, flags, {PAD_W{1'b0}}};

  AST_ILM_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (enReg[4] && $past(enReg[4])) |-> $stable(ilmSel)); // R4
  AST_SYS_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (enReg[1] && $past(enReg[1])) |-> $stable(sysSel)); // R4
  AST_OVP_CLEARS_EN: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ovpClr |=> (enReg == '0)); // R7
  AST_KILL_RAILS_OFF: assert property (@(posedge clk) disable iff (!rstN)
    strobe.railKill |-> (railEn == '0)); // R8
endmodule

// File: rtl/rail_ctrl_bank.sv
module rail_ctrl_bank
  import rail_bank_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  input  logic [7:0]  wrData,
  input  logic        detUv,
  input  logic        detOv,
  input  logic        detOvp,
  input  logic        detAccLow,
  input  logic        detTwarn,
  input  logic        detTsd,
  input  logic        detOc,
  output logic [4:0]  railEn,
  output logic [1:0]  ilmSel,
  output logic [1:0]  cdSel,
  output logic [1:0]  audSel,
  output logic        sysSel,
  output logic [1:0]  accThr,
  output logic [1:0]  uvThr,
  output logic        batMode,
  output logic [15:0] rdWord,
  output logic        batFaultN,
  output logic        accLowN
);
  logic [NUM_DET-1:0] detRaw, detSync;
  bankStrobe_t        strobe;

  always_comb begin
    detRaw           = '0;
    detRaw[DET_OC]   = detOc;
    detRaw[DET_TW]   = detTwarn;
    detRaw[DET_OVP]  = detOvp;
    detRaw[DET_OV]   = detOv;
    detRaw[DET_UV]   = detUv;
    detRaw[DET_ACC]  = detAccLow;
    detRaw[DET_TSD]  = detTsd;
  end

  rail_bank_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .detRaw(detRaw),
    .batMode(batMode), .strobe(strobe), .detSync(detSync),
    .batFaultN(batFaultN), .accLowN(accLowN)
  );

  rail_bank_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .flags(detSync[NUM_FLAG-1:0]), .railEn(railEn), .ilmSel(ilmSel),
    .cdSel(cdSel), .audSel(audSel), .sysSel(sysSel), .accThr(accThr),
    .uvThr(uvThr), .batMode(batMode), .rdWord(rdWord)
  );
endmodule

// File: tb/rail_ctrl_bank_tb.sv
module rail_ctrl_bank_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic detUv = 0, detOv = 0, detOvp = 0, detAccLow = 0, detTwarn = 0, detTsd = 0, detOc = 0;
  logic [4:0] railEn;
  logic [1:0] ilmSel, cdSel, audSel, accThr, uvThr;
  logic sysSel, batMode, batFaultN, accLowN;
  logic [15:0] rdWord;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rail_ctrl_bank u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .detUv(detUv), .detOv(detOv), .detOvp(detOvp), .detAccLow(detAccLow),
    .detTwarn(detTwarn), .detTsd(detTsd), .detOc(detOc), .railEn(railEn),
    .ilmSel(ilmSel), .cdSel(cdSel), .audSel(audSel), .sysSel(sysSel),
    .accThr(accThr), .uvThr(uvThr), .batMode(batMode), .rdWord(rdWord),
    .batFaultN(batFaultN), .accLowN(accLowN)
  );

  // reference model: plain integers, two-deep history per detector
  int mEn = 0, mVsel = 0, mCfg = 0, mIlm = 0, mCd = 0, mAud = 0, mSys = 0;
  int hUv[2], hOv[2], hOvp[2], hAcc[2], hTw[2], hTsd[2], hOc[2];

  always @(posedge clk) begin
    int oldEn;
    oldEn = mEn;
    if (!rstN) begin
      mEn = 0; mVsel = 0; mCfg = 0; mIlm = 0; mCd = 0; mAud = 0; mSys = 0;
      foreach (hUv[i]) begin
        hUv[i] = 0; hOv[i] = 0; hOvp[i] = 0; hAcc[i] = 0; hTw[i] = 0; hTsd[i] = 0; hOc[i] = 0;
      end
    end else begin
      if (hOvp[1] != 0) mEn = 0;
      else if (wrEn && wrAddr == 0) mEn = wrData / 8;
      if (wrEn && wrAddr == 1) mVsel = wrData / 2;
      if (wrEn && wrAddr == 2) mCfg = wrData / 8;
      if (((oldEn / 16) % 2) == 0) mIlm = (mVsel / 32) % 4;
      if (((oldEn / 8) % 2) == 0)  mCd  = (mVsel / 8) % 4;
      if (((oldEn / 4) % 2) == 0)  mAud = (mVsel / 2) % 4;
      if (((oldEn / 2) % 2) == 0)  mSys = mVsel % 2;
      hUv[1] = hUv[0];   hUv[0] = detUv;
      hOv[1] = hOv[0];   hOv[0] = detOv;
      hOvp[1] = hOvp[0]; hOvp[0] = detOvp;
      hAcc[1] = hAcc[0]; hAcc[0] = detAccLow;
      hTw[1] = hTw[0];   hTw[0] = detTwarn;
      hTsd[1] = hTsd[0]; hTsd[0] = detTsd;
      hOc[1] = hOc[0];   hOc[0] = detOc;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      int kill, flagByte, bat;
      kill = (hOvp[1] != 0) || (hTsd[1] != 0);
      flagByte = hAcc[1]*128 + hUv[1]*64 + hOv[1]*32 + hOvp[1]*16 + hTw[1]*8 + hOc[1]*4;
      bat = (hUv[1] | hOv[1] | hOvp[1] | (hTw[1] & (mCfg % 2))) ? 0 : 1;
      check("R2/R7/R8", "railEn", railEn, kill ? 0 : mEn);
      check("R4", "ilmSel", ilmSel, mIlm);
      check("R4", "cdSel", cdSel, mCd);
      check("R4", "audSel", audSel, mAud);
      check("R4", "sysSel", sysSel, mSys);
      check("R5", "thresholds", {accThr, uvThr, batMode}, mCfg);
      check("R3", "rdWord high", rdWord[15:8], mVsel * 2);
      check("R6", "rdWord flags", rdWord[7:0], flagByte);
      check("R9", "batFaultN", batFaultN, bat);
      check("R10", "accLowN", accLowN, hAcc[1] ? 0 : 1);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(int addr, int data);
    wrEn = 1; wrAddr = 2'(addr); wrData = 8'(data);
    step(1);
    wrEn = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rstN = 1;
    step(1);
    @(negedge clk);
    check("R1", "reset railEn", railEn, 0);
    check("R1", "reset rdWord", rdWord, 0);
    check("R1", "reset pins", {batFaultN, accLowN}, 3);
    step(1);
    wr(1, 8'b1001_1111);          // R3: bit 0 dropped
    wr(0, 8'hFF);                 // R2: low bits ignored, all rails on
    wr(1, 8'h00);                 // R4: frozen while enabled
    step(2);
    wr(0, 8'h78);                 // R4: ILM off, its select catches up
    step(2);
    wr(3, 8'hFF);                 // R2: unused address
    wr(2, 8'hFF);                 // R5: mode on
    detUv = 1; step(4); detUv = 0; step(3);
    detOv = 1; step(4); detOv = 0; step(3);
    detAccLow = 1; step(4); detAccLow = 0; step(3);
    detOc = 1; step(4); detOc = 0; step(3);
    detTwarn = 1; step(4);
    wr(2, 8'h00);                 // R9: mode off masks warning
    step(3); detTwarn = 0; step(3);
    @(negedge clk);
    check("R11", "rails after flag-only faults", railEn, 5'h0F);
    step(1);
    detTsd = 1; step(5);
    detTsd = 0; step(4);
    @(negedge clk);
    check("R8", "rails restored after shutdown", railEn, 5'h0F);
    step(1);
    detOvp = 1; step(4);
    wr(0, 8'hF8);                 // R7: ignored during protection
    step(2); detOvp = 0; step(4);
    @(negedge clk);
    check("R7", "rails stay off after release", railEn, 0);
    step(1);
    wr(0, 8'h88);
    step(2);
    for (int k = 0; k < 400; k++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 4) wr($urandom_range(0, 3), $urandom_range(0, 255));
      else if (r < 8) begin
        detUv = 1'($urandom); detOv = 1'($urandom); detAccLow = 1'($urandom);
        detTwarn = 1'($urandom); detOc = 1'($urandom);
        detOvp = ($urandom_range(0, 9) == 0); detTsd = ($urandom_range(0, 9) == 0);
        step(3);
      end else step(1);
    end
    detUv = 0; detOv = 0; detAccLow = 0; detTwarn = 0; detOc = 0; detOvp = 0; detTsd = 0;
    step(3);
    rstN = 0; step(2); rstN = 1; step(1);
    @(negedge clk);
    check("R1", "mid-run reset railEn", railEn, 0);
    check("R1", "mid-run reset rdWord", rdWord, 0);
    step(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule